// File: doc/BRIEF.md
# Multiplexed ADC Control Interface

This block is the register-level front end of a successive-approximation ADC that serves a resistive touch panel and four auxiliary inputs. Software programs a 16-bit control register to power the converter, pick one of eight inputs, choose the reference options and, optionally, hold the conversion until an external sync pin allows it. It then reads the result from a data register that holds a valid flag together with the 10-bit value.

A conversion is launched by a two-step software sequence. The first write sets enable and the input select. The second write repeats that value with the start bit added. The block sees the start bit change from 0 to 1 while the ADC is enabled, clears the valid flag and issues a one-cycle start pulse to the converter. If sync gating is on, it first waits for the synchronised sync pin. When the converter acknowledges, the block captures the result, sets valid and pulses a completion event towards the interrupt logic. Software polls the data register until valid is high. Writing zero to the control register powers the ADC down and abandons any conversion in flight.

The analog converter is outside the block. It is seen only through the start pulse, the selected input, the reference controls and an acknowledge that carries the result.

Top module: `adc_ctrl_if`

## Requirements
- R1: After reset the control register reads 0, the data register reads 0, and `conv_start`, `done_evt` and `conv_power` are low.
- R2: The control register at address 0x66 keeps only the defined bits: 15 enable, 7 start, 5 external reference, 4:2 input select, 1 reference bypass, 0 sync gating. A read returns the written value ANDed with 0x80BF. `conv_power`, `conv_ext_ref`, `conv_chan` and `conv_bypass` follow bits 15, 5, 4:2 and 1.
- R3: A control write with bit 15 set and bit 7 set, while the stored bit 7 is 0, clears the valid flag. With sync gating off, it produces exactly one single-cycle `conv_start` pulse, which begins on the second clock edge after the write.
- R4: A control write whose start bit was already 1 in the stored value launches no conversion and leaves the data register unchanged.
- R5: When `conv_ack` arrives during a conversion, the data register at address 0x68 reads bit 15 = 1, bits 9:0 = `conv_result`, and all other bits 0. `done_evt` is high for exactly one cycle, in the same cycle in which valid rises.
- R6: With bit 0 set, no `conv_start` is issued while `sync_in` is low. After `sync_in` goes high, `conv_start` follows within 4 cycles (two synchroniser stages plus issue).
- R7: A start write with bit 15 clear is ignored. No `conv_start` is issued and the valid flag and result stay unchanged.
- R8: A control write with bit 15 clear abandons a pending or in-flight conversion. A later `conv_ack` sets neither valid nor `done_evt`.
- R9: A `conv_ack` arriving while no conversion is outstanding changes neither the data register nor `done_evt`.
- R10: Writes to any address other than 0x66 change no state, and the data register is read-only. Reads from unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| sync_in | input | 1 | External sync pin, asynchronous |
| conv_power | output | 1 | Converter enable |
| conv_chan | output | 3 | Selected input: 0 X+, 1 X-, 2 Y+, 3 Y-, 4..7 auxiliary 0..3 |
| conv_ext_ref | output | 1 | Use external reference |
| conv_bypass | output | 1 | Connect reference bypass |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_ack | input | 1 | Converter result ready, one cycle |
| conv_result | input | 10 | Converter result, valid with `conv_ack` |
| done_evt | output | 1 | One-cycle conversion-complete event |

## Verification
If the sequencer state goes wrong, the start pulse count shows it at the ports within a few cycles of the write. The count is wrong when a repeated start, a disabled start or an unsynchronised gated start launches a conversion, or when a genuine start launches none. A bad valid or result register shows up on the next read of address 0x68, either as valid stuck high during a conversion or as a stale value after an acknowledge. A wrong abort path shows up when a late acknowledge after power-down sets valid or pulses the completion event.

// File: rtl/adc_ctrl_if.sv
module adc_ctrl_if #(
  parameter int          AW          = 8,
  parameter int          RW          = 10,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  CTRL_ADDR   = 8'h66,
  parameter logic [7:0]  DATA_ADDR   = 8'h68
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  input  logic          sync_in,
  output logic          conv_power,
  output logic [2:0]    conv_chan,
  output logic          conv_ext_ref,
  output logic          conv_bypass,
  output logic          conv_start,
  input  logic          conv_ack,
  input  logic [RW-1:0] conv_result,
  output logic          done_evt
);

  localparam logic [15:0] CTRL_MASK = 16'h80BF;
  localparam int          ZW        = 15 - RW;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_CONV} st_t;

  st_t                    st_q;
  logic [15:0]            ctrl_q;
  logic                   valid_q;
  logic [RW-1:0]          res_q;
  logic [SYNC_STAGES-1:0] sync_sh;
  logic                   start_q;
  logic                   done_q;

  wire        ctrl_wr    = bus_wr && (bus_addr == AW'(CTRL_ADDR));
  wire [15:0] ctrl_nx    = bus_wdata & CTRL_MASK;
  wire        en_nx      = ctrl_nx[15];
  wire        start_edge = ctrl_wr && en_nx && ctrl_nx[7] && !ctrl_q[7];
  wire        sync_ok    = !ctrl_q[0] || sync_sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_sh <= '0;
    else        sync_sh <= SYNC_STAGES'({sync_sh, sync_in});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      ctrl_q  <= '0;
      valid_q <= 1'b0;
      res_q   <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      if (ctrl_wr) ctrl_q <= ctrl_nx;
      if (ctrl_wr && !en_nx) begin
        st_q <= S_IDLE;
      end else if (start_edge) begin
        st_q    <= S_WAIT;
        valid_q <= 1'b0;
      end else begin
        case (st_q)
          S_WAIT: if (sync_ok) begin
            start_q <= 1'b1;
            st_q    <= S_CONV;
          end
          S_CONV: if (conv_ack) begin
            res_q   <= conv_result;
            valid_q <= 1'b1;
            done_q  <= 1'b1;
            st_q    <= S_IDLE;
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  assign conv_power   = ctrl_q[15];
  assign conv_chan    = ctrl_q[4:2];
  assign conv_ext_ref = ctrl_q[5];
  assign conv_bypass  = ctrl_q[1];
  assign conv_start   = start_q;
  assign done_evt     = done_q;

  always_comb begin
    if (bus_addr == AW'(CTRL_ADDR))      bus_rdata = ctrl_q;
    else if (bus_addr == AW'(DATA_ADDR)) bus_rdata = {valid_q, {ZW{1'b0}}, res_q};
    else                                 bus_rdata = '0;
  end

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r5_valid_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> done_q);

  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  a_r3_valid_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE) |-> !valid_q);

  a_r6_sync_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT && ctrl_q[0] && !sync_sh[SYNC_STAGES-1]) |=> !start_q);

  a_r8_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !bus_wdata[15]) |=> (st_q == S_IDLE && !start_q && !done_q));

  a_r7_disabled_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !bus_wdata[15]) |=> $stable(valid_q));

endmodule

// File: tb/adc_ctrl_if_tb.sv
module adc_ctrl_if_tb;
  localparam int CLK_P = 10;
  localparam logic [7:0] A_CTRL = 8'h66;
  localparam logic [7:0] A_DATA = 8'h68;
  localparam logic [15:0] EN = 16'h8000, ST = 16'h0080, SY = 16'h0001;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic sync_in = 0;
  logic conv_power, conv_ext_ref, conv_bypass, conv_start, done_evt;
  logic [2:0] conv_chan;
  logic conv_ack = 0;
  logic [9:0] conv_result = 0;

  int checks = 0, fails = 0;
  int n_start = 0, n_done = 0;
  int lat_set = 3, lat_cnt = 0, seq = 0;
  logic stray_req = 0;
  logic [9:0] last_res = 0;

  adc_ctrl_if u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_in(sync_in),
    .conv_power(conv_power), .conv_chan(conv_chan), .conv_ext_ref(conv_ext_ref),
    .conv_bypass(conv_bypass), .conv_start(conv_start), .conv_ack(conv_ack),
    .conv_result(conv_result), .done_evt(done_evt));

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    if (conv_start) n_start <= n_start + 1;
    if (done_evt)   n_done  <= n_done + 1;
  end

  always @(posedge clk) begin
    conv_ack <= 1'b0;
    if (stray_req) begin
      conv_ack    <= 1'b1;
      conv_result <= 10'h3FF;
    end
    if (lat_cnt > 0) begin
      lat_cnt <= lat_cnt - 1;
      if (lat_cnt == 1) begin
        conv_ack    <= 1'b1;
        conv_result <= last_res;
      end
    end
    if (conv_start) begin
      lat_cnt  <= lat_set;
      last_res <= 10'({conv_chan, 7'd0}) ^ 10'(seq * 37 + 5);
      seq      <= seq + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_valid(output logic [15:0] v);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); rd(A_DATA, v);
      if (v[15]) break;
    end
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(A_CTRL, v); check(v == 0, "R1 ctrl", v, 0);
    rd(A_DATA, v); check(v == 0, "R1 data", v, 0);
    check(!conv_start && !done_evt && !conv_power, "R1 outputs",
          {conv_start, done_evt, conv_power}, 0);
  endtask

  task automatic t_readback;
    logic [15:0] v;
    wr(A_CTRL, 16'hFF7F);
    rd(A_CTRL, v); check(v == 16'h803F, "R2 readback", v, 16'h803F);
    check({conv_power, conv_chan, conv_ext_ref, conv_bypass} == 6'b111111,
          "R2 pins", {conv_power, conv_chan, conv_ext_ref, conv_bypass}, 6'h3F);
    wr(A_CTRL, 16'h0000);
    rd(A_CTRL, v); check(v == 0 && !conv_power, "R8 power down", v, 0);
  endtask

  task automatic t_conv(input logic [2:0] ch);
    logic [15:0] v; int s0, d0;
    wr(A_CTRL, EN | 16'(ch) << 2);
    s0 = n_start; d0 = n_done;
    wr(A_CTRL, EN | ST | 16'(ch) << 2);
    rd(A_DATA, v); check(v[15] == 0, "R3 valid cleared", v, 0);
    check(n_start == s0, "R3 no pulse yet", n_start - s0, 0);
    @(negedge clk);
    check(conv_start == 1 && conv_chan == ch, "R3 start pulse", {conv_start, conv_chan}, {1'b1, ch});
    wait_valid(v);
    check(v == {6'b100000, last_res}, "R5 data", v, {6'b100000, last_res});
    check(n_start - s0 == 1, "R3 single start", n_start - s0, 1);
    @(negedge clk);
    check(n_done - d0 == 1, "R5 done count", n_done - d0, 1);
  endtask

  task automatic t_repeat_start;
    logic [15:0] v0, v; int s0;
    rd(A_DATA, v0); s0 = n_start;
    wr(A_CTRL, EN | ST | 16'h0008);
    idle(15);
    rd(A_DATA, v);
    check(n_start == s0 && v == v0, "R4 repeat start ignored", v, v0);
  endtask

  task automatic t_disabled_start;
    logic [15:0] v0, v; int s0;
    wr(A_CTRL, 16'h0000);
    rd(A_DATA, v0); s0 = n_start;
    wr(A_CTRL, ST | 16'h000C);
    idle(15);
    rd(A_DATA, v);
    check(n_start == s0 && v == v0 && v0[15], "R7 disabled start ignored", v, v0);
    wr(A_CTRL, 16'h0000);
  endtask

  task automatic t_sync;
    logic [15:0] v; int s0;
    sync_in = 0;
    wr(A_CTRL, EN | SY | 16'h0014);
    s0 = n_start;
    wr(A_CTRL, EN | SY | ST | 16'h0014);
    idle(20);
    rd(A_DATA, v);
    check(n_start == s0 && !v[15], "R6 held by sync", n_start - s0, 0);
    sync_in = 1;
    idle(4);
    check(n_start - s0 == 1, "R6 start after sync", n_start - s0, 1);
    wait_valid(v);
    check(v == {6'b100000, last_res}, "R6 result", v, {6'b100000, last_res});
    sync_in = 0;
    wr(A_CTRL, 16'h0000);
  endtask

  task automatic t_abort;
    logic [15:0] v; int s0, d0;
    lat_set = 20;
    wr(A_CTRL, EN | 16'h0004);
    s0 = n_start; d0 = n_done;
    wr(A_CTRL, EN | ST | 16'h0004);
    idle(2);
    check(n_start - s0 == 1, "R8 conversion began", n_start - s0, 1);
    wr(A_CTRL, 16'h0000);
    idle(30);
    rd(A_DATA, v);
    check(!v[15] && n_done == d0, "R8 late ack ignored", v, 0);
    lat_set = 3;
  endtask

  task automatic t_stray;
    logic [15:0] v0, v; int d0;
    t_conv(3'd6);
    wr(A_CTRL, 16'h0000);
    rd(A_DATA, v0); d0 = n_done;
    @(negedge clk); stray_req = 1;
    @(negedge clk); stray_req = 0;
    idle(3);
    rd(A_DATA, v);
    check(v == v0 && n_done == d0, "R9 stray ack", v, v0);
  endtask

  task automatic t_other_addr;
    logic [15:0] d0, c0, v; int s0;
    rd(A_DATA, d0); rd(A_CTRL, c0); s0 = n_start;
    wr(A_DATA, 16'hFFFF);
    wr(8'h10, 16'hFFFF);
    idle(8);
    rd(A_DATA, v); check(v == d0, "R10 data read-only", v, d0);
    rd(A_CTRL, v); check(v == c0 && n_start == s0, "R10 ctrl untouched", v, c0);
    rd(8'h10, v); check(v == 0, "R10 unmapped read", v, 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1;
    idle(2);
    t_reset();
    t_readback();
    t_conv(3'd0);
    t_repeat_start();
    wr(A_CTRL, 16'h0000);
    t_conv(3'd2);
    t_conv(3'd7);
    t_disabled_start();
    t_sync();
    t_abort();
    t_stray();
    t_other_addr();
    summary();
  end
endmodule